// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital sequencer of a 12-bit successive approximation converter. The analog sample-and-hold, the resistor ladder and the comparator sit outside it. The block drives a trial code onto the ladder and samples one comparator bit for each step. It then settles the bits one at a time, from the most significant down to the least significant.

Each settled bit leaves the block at once on a serial line, together with a one-clock valid strobe. A delay memory can store the stream directly, so the trial register only serves the comparison. When the last bit is settled, a one-clock done flag pulses and the complete code is presented on a parallel output.

A start pulse begins a conversion. A start pulse that arrives during a conversion has no effect. A step-length input sets how many clocks each trial code is held before the comparator is sampled, which gives the external ladder and comparator time to settle.

Top module: `sar_seq`

## Requirements
- R1: During and right after reset, `busy`, `done` and `ser_valid` are low, and `trial_code` and `result` are zero.
- R2: A `start` sampled high while idle raises `busy` on the next cycle. At the same moment `trial_code` becomes 0x800: only bit 11 is set, which is the half-scale weight.
- R3: Every step lasts `step_len`+1 clocks, and `trial_code` does not change inside a step.
- R4: At the end of a step, the bit under trial is cleared when `cmp_high` is 1 (trial above the input) and kept when `cmp_high` is 0. In the same update the next lower bit is set as the new trial bit. Bits already settled are not changed.
- R5: `ser_valid` pulses for one clock per settled bit, 12 times per conversion. Each pulse comes `step_len`+1 cycles after the previous one, or after the start edge for the first. `ser_bit` carries the settled value (1 = kept), MSB first.
- R6: `done` pulses for one clock in the same cycle as the 12th `ser_valid`, which is 12·(`step_len`+1) cycles after the start edge. `busy` is low in that cycle.
- R7: When `done` is high, `result` equals the final code, and `result` keeps that value until the next `done`.
- R8: A `start` sampled while `busy` is high does not change the step timing, the trial codes or the result.
- R9: With a monotonic comparator (`cmp_high` = trial code greater than input code), the final code equals the 12-bit input code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when idle |
| step_len | input | 8 | Clocks per step minus one |
| cmp_high | input | 1 | Comparator: trial voltage above sampled input |
| trial_code | output | 12 | Code driven to the ladder DAC |
| ser_bit | output | 1 | Value of the bit just settled |
| ser_valid | output | 1 | One-clock strobe per settled bit |
| done | output | 1 | One-clock pulse after the LSB is settled |
| result | output | 12 | Final code of the latest conversion |
| busy | output | 1 | Conversion in progress |

## Verification
Counting from the clock edge that samples `start`, `busy` and the 0x800 trial code are due one edge later. The k-th serial strobe is due exactly k·(`step_len`+1) edges later, and `done` with the final `result` is due together with the 12th strobe. The bench numbers every edge after the start edge and samples 1 ns after each edge. It predicts `ser_valid`, `ser_bit`, `done` and the trial code from that edge number alone, so it checks every output on every cycle of a conversion. Runs with a start injected in mid-conversion reuse the same edge count, so a restart shows up as a timing mismatch.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W  = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] step_len,
  input  logic          cmp_high,
  output logic [W-1:0]  trial_code,
  output logic          ser_bit,
  output logic          ser_valid,
  output logic          done,
  output logic [W-1:0]  result,
  output logic          busy
);
  localparam int IW = $clog2(W);

  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [W-1:0]  settled;

  wire keep   = ~cmp_high;
  wire last   = (idx == '0);
  wire decide = busy && (cnt == step_len);
  wire [W-1:0] next_bit = (W'(1) << idx) >> 1;

  always_comb begin
    settled      = trial_code;
    settled[idx] = keep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trial_code <= '0;
      idx        <= '0;
      cnt        <= '0;
      busy       <= 1'b0;
      ser_bit    <= 1'b0;
      ser_valid  <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
    end else begin
      ser_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          trial_code <= W'(1) << (W - 1);
          idx        <= IW'(W - 1);
          cnt        <= '0;
          busy       <= 1'b1;
        end
      end else if (decide) begin
        ser_bit   <= keep;
        ser_valid <= 1'b1;
        cnt       <= '0;
        if (last) begin
          trial_code <= settled;
          result     <= settled;
          busy       <= 1'b0;
          done       <= 1'b1;
        end else begin
          trial_code <= settled | next_bit;
          idx        <= idx - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] trial_code,
  input logic         ser_valid,
  input logic         done,
  input logic [W-1:0] result,
  input logic         busy
);
  // R2
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> trial_code == (W'(1) << (W - 1)));

  // R3
  step_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !ser_valid) |-> $stable(trial_code));

  // R5
  strobe_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (busy || done));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ser_valid && !busy));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result == trial_code);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result)));
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trial_code(trial_code), .ser_valid(ser_valid),
  .done(done), .result(result), .busy(busy)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  step_len = '0;
  logic        cmp_high;
  logic [11:0] trial_code, result;
  logic        ser_bit, ser_valid, done, busy;

  int checks = 0;
  int errors = 0;
  int kd = 0;
  logic        use_pat = 1'b0;
  logic [11:0] pat = '0;
  logic [11:0] vin = '0;

  always #(PERIOD/2) clk = ~clk;

  assign cmp_high = use_pat ? ((kd < 12) ? pat[11 - kd] : 1'b0)
                            : (trial_code > vin);

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .step_len(step_len),
    .cmp_high(cmp_high), .trial_code(trial_code), .ser_bit(ser_bit),
    .ser_valid(ser_valid), .done(done), .result(result), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_code(input logic p, input logic [11:0] v,
                                           input logic [11:0] pt);
    return p ? ~pt : v;
  endfunction

  function automatic logic [11:0] exp_trial(input logic [11:0] fin, input int k);
    logic [11:0] m;
    m = (k >= 12) ? 12'hFFF : ~(12'hFFF >> k);
    return (fin & m) | ((k < 12) ? (12'h800 >> k) : 12'h000);
  endfunction

  task automatic convert(input logic p, input logic [11:0] v, input logic [11:0] pt,
                         input int len, input int inj);
    int total;
    logic [11:0] fin;
    use_pat = p; vin = v; pat = pt; step_len = 8'(len); kd = 0;
    fin = exp_code(p, v, pt);
    total = 12 * (len + 1);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(trial_code == 12'h800, "R2 first trial", trial_code, 12'h800);
    for (int n = 1; n <= total + 2; n++) begin
      bit ev;
      @(posedge clk); #1;
      start = 1'b0;
      ev = (n <= total) && (n % (len + 1) == 0);
      if (ev) kd = n / (len + 1);
      chk(ser_valid == ev, "R5 strobe timing", ser_valid, ev);
      if (ev) chk(ser_bit == fin[12 - kd], "R5 serial bit", ser_bit, fin[12 - kd]);
      chk(done == (n == total), "R6 done timing", done, (n == total));
      if (n <= total)
        chk(trial_code == exp_trial(fin, kd), "R3 R4 trial code",
            trial_code, exp_trial(fin, kd));
      if (n == total) begin
        chk(busy == 1'b0, "R6 busy low", busy, 0);
        chk(result == fin, p ? "R7 result" : "R9 ladder result", result, fin);
      end
      if (n == inj) start = 1'b1;
    end
    chk(result == fin, "R7 result hold", result, fin);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0 && done == 0 && ser_valid == 0, "R1 flags", {busy, done, ser_valid}, 0);
    chk(trial_code == 0 && result == 0, "R1 regs", trial_code, 0);
    @(negedge clk); rst_n = 1'b1;
    // directed corners: R9 full scale and zero, R8 restart attempts
    convert(1'b0, 12'h000, 12'h000, 0, -1);
    convert(1'b0, 12'hFFF, 12'h000, 1, -1);
    convert(1'b0, 12'h800, 12'h000, 5, 7);
    convert(1'b0, 12'h7FF, 12'h000, 2, 34);
    convert(1'b1, 12'h000, 12'hA5C, 3, 1);
    // random ladder and random comparator patterns
    for (int i = 0; i < 10; i++)
      convert(1'b0, 12'($urandom), 12'h000, int'($urandom % 4), int'($urandom % 30));
    for (int i = 0; i < 6; i++)
      convert(1'b1, 12'h000, 12'($urandom), int'($urandom % 3), -1);
    repeat (4) @(posedge clk);
    #1;
    chk(done == 1'b0 && busy == 1'b0, "R7 idle after run", {done, busy}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule